// File: doc/BRIEF.md
# Dual Wiper Register Command Controller

This block is the command side of a two-channel digital potentiometer. A byte-framed serial link, bounded by an active-low chip select and paced by a one-cycle byte strobe, carries an identification byte, then an instruction byte, then optional data bytes. A frame goes ahead only when the identification byte carries the fixed type code and the strapped device address. The controller then decodes the opcode, the data-register pointer and the potentiometer pointer.

Each potentiometer has one volatile 8-bit wiper register, which drives the switch decoder outside this block, and four 8-bit data registers that stand in for non-volatile storage. Wipers can be written directly, loaded from a data register, or stepped one position with saturation. Data registers can be read, written, or loaded from the wiper. Writes to storage are held pending and are committed only when chip select is released. A busy period follows, set by a parameter in clock cycles, and it can be observed with a status read.

Top module: `potcmd_ctrl`

## Requirements
- R1: A frame is acted on only if its first byte has bits 7..4 equal to TYPE_ID (default 4'b0101), bits 3..2 equal to 00 and bits 1..0 equal to `strap_addr`. Otherwise every later byte of that frame is ignored.
- R2: In the instruction byte, bits 7..4 are the opcode, bits 3..2 select data register 0..3 and bit 0 selects potentiometer 0 or 1. An instruction byte with bit 1 set is ignored, together with the rest of its frame.
- R3: After reset, data register r of potentiometer p holds byte p*4+r of DR_INIT (bits 8*(p*4+r)+7 down to 8*(p*4+r)). Each wiper holds its own data register 0, `wip` is 0 and `rd_vld` is 0.
- R4: Opcode 0xA loads the first data byte of the frame into the selected wiper on the clock edge that takes that byte. Later data bytes of the same frame are ignored. `wiper_pos[7:0]` is potentiometer 0 and `wiper_pos[15:8]` is potentiometer 1.
- R5: Opcode 0xD copies the selected data register into the selected wiper on the edge that takes the instruction byte.
- R6: Opcode 0x2 moves the selected wiper one step for every data byte: up if bit 0 of the byte is 1, down if it is 0. The wiper stays at 0xFF going up and at 0x00 going down.
- R7: Opcodes 0x9 (wiper), 0xB (data register) and 0x5 (status, `{7'b0, wip}`) raise `rd_vld` for exactly one cycle, in the cycle after the instruction byte is strobed. `rd_data` carries the value and then holds it.
- R8: Opcode 0xC writes its first data byte to the selected data register, but only on the first clock edge that sees `cs_n` high after that byte. If chip select rises before any data byte has arrived, nothing changes and `wip` stays low.
- R9: Opcode 0xE takes the selected wiper's value at the instruction byte and commits it to the selected data register when chip select rises.
- R10: Each commit sets `wip`, which stays high for exactly WRITE_CYCLES cycles starting on the commit edge.
- R11: A 0xC data byte or a 0xE instruction byte is rejected if `wip` is high on the edge that takes it. Wiper commands, reads and status reads are still carried out while `wip` is high.
- R12: Opcodes other than 0x2, 0x5, 0x9, 0xA, 0xB, 0xC, 0xD and 0xE change no register and produce no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select; a rise ends the frame |
| rx_vld | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| strap_addr | input | 2 | Strapped device address |
| wiper_pos | output | 16 | Wiper registers, potentiometer 1 in the upper byte |
| wip | output | 1 | Storage commit in progress |
| rd_vld | output | 1 | Read result strobe |
| rd_data | output | 8 | Read result |

## Verification
The risky coincidence is a new storage write arriving in the same cycle that the busy timer expires. The bench commits one write and then opens a second frame whose data byte is strobed on a counted cycle. In one run that byte lands on the last busy cycle, where it must be rejected; in the other it lands one cycle later, where it must be accepted. Read-back of the target register after each run decides the outcome. A behavioural model runs alongside and is compared with the wipers, `wip` and the read port on every clock.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;
   localparam int BYTE_W = 8;
   localparam int NPOT   = 2;
   localparam int NREG   = 4;

   typedef enum logic [3:0] {
      OP_STEP = 4'h2,
      OP_STAT = 4'h5,
      OP_RDW  = 4'h9,
      OP_WRW  = 4'hA,
      OP_RDD  = 4'hB,
      OP_WRD  = 4'hC,
      OP_D2W  = 4'hD,
      OP_W2D  = 4'hE
   } op_e;

   typedef struct packed {
      logic [3:0] op;
      logic [1:0] dsel;
      logic       pot;
   } instr_t;
endpackage

// File: rtl/potcmd_frame.sv
module potcmd_frame
   import potcmd_pkg::*;
#(
   parameter logic [3:0] TYPE_ID = 4'b0101
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       rx_vld,
   input  logic [7:0] rx_byte,
   input  logic [1:0] strap,
   output logic       cs_rise,
   output logic       ins_evt,
   output instr_t     ins_now,
   output logic       dat_evt,
   output logic       dat_first,
   output instr_t     ins_held
);
   typedef enum logic [1:0] {PH_ID, PH_INS, PH_DATA, PH_SKIP} phase_e;

   phase_e ph_q;
   logic   cs_q;
   logic   fresh_q;
   instr_t held_q;
   logic   strobe;
   logic   id_ok;

   assign strobe    = rx_vld & ~cs_n;
   assign id_ok     = (rx_byte[7:4] == TYPE_ID) && (rx_byte[3:2] == 2'b00)
                      && (rx_byte[1:0] == strap);
   assign ins_now   = {rx_byte[7:2], rx_byte[0]};
   assign ins_evt   = strobe && (ph_q == PH_INS) && !rx_byte[1];
   assign dat_evt   = strobe && (ph_q == PH_DATA);
   assign dat_first = fresh_q;
   assign ins_held  = held_q;
   assign cs_rise   = cs_n & ~cs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q    <= 1'b1;
         ph_q    <= PH_ID;
         fresh_q <= 1'b0;
         held_q  <= '0;
      end else begin
         cs_q <= cs_n;
         if (cs_n) begin
            ph_q    <= PH_ID;
            fresh_q <= 1'b0;
         end else if (strobe) begin
            case (ph_q)
               PH_ID:  ph_q <= id_ok ? PH_INS : PH_SKIP;
               PH_INS: begin
                  if (rx_byte[1]) begin
                     ph_q <= PH_SKIP;
                  end else begin
                     ph_q    <= PH_DATA;
                     held_q  <= ins_now;
                     fresh_q <= 1'b1;
                  end
               end
               PH_DATA: fresh_q <= 1'b0;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/potcmd_wiper.sv
module potcmd_wiper #(
   parameter int         W    = 8,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         step,
   input  logic         up,
   output logic [W-1:0] pos
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= INIT;
      end else if (ld) begin
         pos <= ld_val;
      end else if (step) begin
         if (up && pos != TOP)
            pos <= pos + 1'b1;
         else if (!up && pos != '0)
            pos <= pos - 1'b1;
      end
   end
endmodule

// File: rtl/potcmd_store.sv
module potcmd_store #(
   parameter int                  W            = 8,
   parameter int                  NCELL        = 8,
   parameter int                  WRITE_CYCLES = 625000,
   parameter logic [W*NCELL-1:0]  INIT         = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       arm,
   input  logic [$clog2(NCELL)-1:0]   arm_idx,
   input  logic [W-1:0]               arm_val,
   input  logic                       cs_rise,
   output logic                       wip,
   output logic [W*NCELL-1:0]         cells
);
   localparam int IW = $clog2(NCELL);
   localparam int CW = $clog2(WRITE_CYCLES + 1);

   logic          pend_q;
   logic [IW-1:0] pidx_q;
   logic [W-1:0]  pval_q;
   logic [CW-1:0] cnt_q;
   logic          commit;

   if (WRITE_CYCLES < 1) begin : g_bad_cycles
      $error("WRITE_CYCLES must be at least 1");
   end
   if (NCELL != (1 << IW)) begin : g_bad_cells
      $error("NCELL must be a power of two");
   end

   assign commit = cs_rise & pend_q;

   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      logic [W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cell_q <= INIT[i*W +: W];
         else if (commit && pidx_q == IW'(i))
            cell_q <= pval_q;
      end
      assign cells[i*W +: W] = cell_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pidx_q <= '0;
         pval_q <= '0;
      end else if (cs_rise) begin
         pend_q <= 1'b0;
      end else if (arm && !wip) begin
         pend_q <= 1'b1;
         pidx_q <= arm_idx;
         pval_q <= arm_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wip   <= 1'b0;
         cnt_q <= '0;
      end else if (commit) begin
         wip   <= 1'b1;
         cnt_q <= CW'(WRITE_CYCLES);
      end else if (wip) begin
         if (cnt_q == CW'(1))
            wip <= 1'b0;
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/potcmd_ctrl.sv
module potcmd_ctrl
   import potcmd_pkg::*;
#(
   parameter int          WRITE_CYCLES = 625000,
   parameter logic [63:0] DR_INIT      = 64'h0,
   parameter logic [3:0]  TYPE_ID      = 4'b0101
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_n,
   input  logic        rx_vld,
   input  logic [7:0]  rx_byte,
   input  logic [1:0]  strap_addr,
   output logic [15:0] wiper_pos,
   output logic        wip,
   output logic        rd_vld,
   output logic [7:0]  rd_data
);
   localparam int NCELL = NPOT * NREG;
   localparam int IW    = $clog2(NCELL);

   if (NCELL * BYTE_W != 64) begin : g_bad_init
      $error("DR_INIT width does not match the cell count");
   end

   logic        cs_rise, ins_evt, dat_evt, dat_first;
   instr_t      ins_now, ins_held;
   logic [NCELL*BYTE_W-1:0] cells;
   logic [IW-1:0] now_idx, held_idx;
   logic        d2w, wrw, stp, arm, is_read;
   logic [IW-1:0] arm_idx;
   logic [7:0]  arm_val;

   potcmd_frame #(.TYPE_ID(TYPE_ID)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_vld(rx_vld),
      .rx_byte(rx_byte), .strap(strap_addr), .cs_rise(cs_rise),
      .ins_evt(ins_evt), .ins_now(ins_now), .dat_evt(dat_evt),
      .dat_first(dat_first), .ins_held(ins_held)
   );

   assign now_idx  = {ins_now.pot, ins_now.dsel};
   assign held_idx = {ins_held.pot, ins_held.dsel};
   assign d2w      = ins_evt && (ins_now.op == OP_D2W);
   assign wrw      = dat_evt && dat_first && (ins_held.op == OP_WRW);
   assign stp      = dat_evt && (ins_held.op == OP_STEP);

   for (genvar p = 0; p < NPOT; p++) begin : g_pot
      logic ld;
      assign ld = (d2w && ins_now.pot == 1'(p)) || (wrw && ins_held.pot == 1'(p));
      potcmd_wiper #(.W(BYTE_W), .INIT(DR_INIT[p*NREG*BYTE_W +: BYTE_W])) u_wiper (
         .clk(clk), .rst_n(rst_n), .ld(ld),
         .ld_val(d2w ? cells[now_idx*BYTE_W +: BYTE_W] : rx_byte),
         .step(stp && ins_held.pot == 1'(p)), .up(rx_byte[0]),
         .pos(wiper_pos[p*BYTE_W +: BYTE_W])
      );
   end

   assign arm     = (dat_evt && dat_first && ins_held.op == OP_WRD)
                    || (ins_evt && ins_now.op == OP_W2D);
   assign arm_idx = ins_evt ? now_idx : held_idx;
   assign arm_val = ins_evt ? wiper_pos[ins_now.pot*BYTE_W +: BYTE_W] : rx_byte;

   potcmd_store #(
      .W(BYTE_W), .NCELL(NCELL), .WRITE_CYCLES(WRITE_CYCLES), .INIT(DR_INIT)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .arm(arm), .arm_idx(arm_idx),
      .arm_val(arm_val), .cs_rise(cs_rise), .wip(wip), .cells(cells)
   );

   assign is_read = ins_evt && (ins_now.op == OP_RDW || ins_now.op == OP_RDD
                                || ins_now.op == OP_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_vld  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_vld <= is_read;
         if (is_read) begin
            case (ins_now.op)
               OP_RDW:  rd_data <= wiper_pos[ins_now.pot*BYTE_W +: BYTE_W];
               OP_RDD:  rd_data <= cells[now_idx*BYTE_W +: BYTE_W];
               default: rd_data <= {7'b0, wip};
            endcase
         end
      end
   end
endmodule

// File: rtl/potcmd_ctrl_chk.sv
module potcmd_ctrl_chk #(
   parameter int WRITE_CYCLES = 625000
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        rx_vld,
   input logic [15:0] wiper_pos,
   input logic        wip,
   input logic        rd_vld
);
   localparam int CW = $clog2(WRITE_CYCLES + 2);
   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         run_q <= '0;
      else if (wip)
         run_q <= run_q + 1'b1;
      else
         run_q <= '0;
   end

   // R7: read strobe lasts one cycle and follows a strobed byte in a frame
   assert_rd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |=> !rd_vld);
   assert_rd_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |-> ($past(rx_vld) && !$past(cs_n)));

   // R8: a busy period only starts on an edge that saw chip select high
   assert_commit_on_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(cs_n));

   // R10: busy period never exceeds its length and ends exactly at it
   assert_wip_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wip |-> (run_q < CW'(WRITE_CYCLES)));
   assert_wip_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> ($past(run_q) == CW'(WRITE_CYCLES - 1)));

   // R4: wipers never move on an edge that sees no active frame
   assert_idle_wiper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable(wiper_pos));
endmodule

bind potcmd_ctrl potcmd_ctrl_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_vld(rx_vld),
   .wiper_pos(wiper_pos), .wip(wip), .rd_vld(rd_vld)
);

// File: tb/sim_potcmd_ctrl.sv
`timescale 1ns/1ps
module sim_potcmd_ctrl;
   localparam int          WC      = 20;
   localparam logic [63:0] DR_INIT = 64'h11_22_FF_01_C4_00_5A_80;
   localparam logic [1:0]  STRAP   = 2'b10;
   localparam logic [7:0]  ID      = 8'h52;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        rx_vld = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic [15:0] wiper_pos;
   logic        wip, rd_vld;
   logic [7:0]  rd_data;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   potcmd_ctrl #(.WRITE_CYCLES(WC), .DR_INIT(DR_INIT)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_vld(rx_vld),
      .rx_byte(rx_byte), .strap_addr(STRAP), .wiper_pos(wiper_pos),
      .wip(wip), .rd_vld(rd_vld), .rd_data(rd_data)
   );

   // behavioural reference model
   logic [7:0] mdr [8];
   logic [7:0] mw  [2];
   int         mleft, mph, mdi, mpot, mpidx;
   logic [3:0] mop;
   logic [7:0] mpval, mrdd;
   logic       mpend, mcsq, mrdv, mfresh, busy;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) mdr[i] = DR_INIT[i*8 +: 8];
         mw[0] = mdr[0]; mw[1] = mdr[4];
         mleft = 0; mpend = 1'b0; mph = 0; mcsq = 1'b1;
         mrdv = 1'b0; mrdd = 8'h00; mfresh = 1'b0; mop = 4'h0;
      end else begin
         busy = (mleft > 0);
         mrdv = 1'b0;
         if (mleft > 0) mleft = mleft - 1;
         if (cs_n) begin
            if (!mcsq && mpend) begin
               mdr[mpidx] = mpval;
               mleft = WC;
            end
            mpend = 1'b0; mph = 0; mfresh = 1'b0;
         end else if (rx_vld) begin
            if (mph == 0) begin
               mph = (rx_byte[7:4] == 4'b0101 && rx_byte[3:2] == 2'b00
                      && rx_byte[1:0] == STRAP) ? 1 : 3;
            end else if (mph == 1) begin
               if (rx_byte[1]) mph = 3;
               else begin
                  mop = rx_byte[7:4]; mpot = int'(rx_byte[0]);
                  mdi = mpot * 4 + int'(rx_byte[3:2]);
                  mph = 2; mfresh = 1'b1;
                  case (mop)
                     4'h9: begin mrdv = 1'b1; mrdd = mw[mpot]; end
                     4'hB: begin mrdv = 1'b1; mrdd = mdr[mdi]; end
                     4'h5: begin mrdv = 1'b1; mrdd = {7'b0, busy}; end
                     4'hD: mw[mpot] = mdr[mdi];
                     4'hE: if (!busy) begin mpend = 1'b1; mpidx = mdi; mpval = mw[mpot]; end
                     default: ;
                  endcase
               end
            end else if (mph == 2) begin
               if (mop == 4'hA && mfresh) mw[mpot] = rx_byte;
               if (mop == 4'hC && mfresh && !busy) begin
                  mpend = 1'b1; mpidx = mdi; mpval = rx_byte;
               end
               if (mop == 4'h2) begin
                  if (rx_byte[0] && mw[mpot] != 8'hFF) mw[mpot] = mw[mpot] + 8'h01;
                  else if (!rx_byte[0] && mw[mpot] != 8'h00) mw[mpot] = mw[mpot] - 8'h01;
               end
               mfresh = 1'b0;
            end
         end
         mcsq = cs_n;
      end
   end

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R4 R5 R6 R12 wiper model", wiper_pos, {mw[1], mw[0]});
         check("R10 R11 wip model", {15'b0, wip}, {15'b0, mleft > 0});
         check("R7 rd_vld model", {15'b0, rd_vld}, {15'b0, mrdv});
         check("R7 rd_data model", {8'h0, rd_data}, {8'h0, mrdd});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic tx(input logic [7:0] b);
      @(negedge clk); rx_vld = 1'b1; rx_byte = b;
      @(negedge clk); rx_vld = 1'b0;
   endtask
   task automatic sel();   @(negedge clk); cs_n = 1'b0; endtask
   task automatic desel(); @(negedge clk); cs_n = 1'b1; endtask

   task automatic frame(input logic [7:0] id, input logic [7:0] ins,
                        input int nd, input logic [7:0] d0, input logic [7:0] d1);
      sel(); tx(id); tx(ins);
      if (nd > 0) tx(d0);
      if (nd > 1) tx(d1);
      desel();
   endtask

   task automatic rd_chk(input logic [7:0] ins, input logic [7:0] exp, input string tag);
      sel(); tx(ID); tx(ins);
      check(tag, {15'b0, rd_vld}, 16'h0001);
      check(tag, {8'h0, rd_data}, {8'h0, exp});
      desel();
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && wip; i++) @(negedge clk);
   endtask

   task automatic coincide(input int k_dat, input logic [7:0] d);
      sel(); tx(ID); tx(8'hCC); tx(8'h5D);
      @(negedge clk); cs_n = 1'b1;
      for (int k = 1; k <= k_dat + 2; k++) begin
         @(negedge clk);
         case (k)
            1: cs_n = 1'b0;
            2: begin rx_vld = 1'b1; rx_byte = ID; end
            4: begin rx_vld = 1'b1; rx_byte = 8'hC9; end
            default: rx_vld = 1'b0;
         endcase
         if (k == k_dat) begin rx_vld = 1'b1; rx_byte = d; end
         if (k == k_dat + 2) cs_n = 1'b1;
      end
      @(negedge clk);
      wait_idle();
   endtask

   initial begin
      int hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 reset wipers", wiper_pos, 16'h0180);
      check("R3 reset wip", {15'b0, wip}, 16'h0000);
      check("R3 reset rd_vld", {15'b0, rd_vld}, 16'h0000);

      frame(8'h62, 8'hA0, 1, 8'h33, 8'h00);
      frame(8'h56, 8'hA0, 1, 8'h33, 8'h00);
      frame(8'h51, 8'hA0, 1, 8'h33, 8'h00);
      check("R1 bad id ignored", wiper_pos, 16'h0180);

      frame(ID, 8'hA1, 2, 8'h40, 8'h41);
      check("R4 direct write first byte", wiper_pos, 16'h4080);
      frame(ID, 8'hA2, 1, 8'h99, 8'h00);
      check("R2 bit1 set ignored", wiper_pos, 16'h4080);

      frame(ID, 8'h21, 2, 8'h00, 8'h00);
      check("R6 step down twice", wiper_pos, 16'h3E80);
      frame(ID, 8'hD8, 0, 8'h00, 8'h00);
      check("R5 transfer to wiper", wiper_pos, 16'h3E00);
      frame(ID, 8'h20, 1, 8'h00, 8'h00);
      check("R6 floor saturation", wiper_pos, 16'h3E00);
      frame(ID, 8'hD5, 0, 8'h00, 8'h00);
      frame(ID, 8'h21, 2, 8'h01, 8'h01);
      check("R6 ceiling saturation", wiper_pos, 16'hFF00);

      rd_chk(8'hBC, 8'hC4, "R7 read data register");
      rd_chk(8'h91, 8'hFF, "R7 read wiper");
      rd_chk(8'h50, 8'h00, "R7 status idle");

      frame(ID, 8'hC5, 1, 8'h77, 8'h00);
      @(negedge clk);
      check("R10 wip after commit", {15'b0, wip}, 16'h0001);
      rd_chk(8'h50, 8'h01, "R7 status busy");
      frame(ID, 8'hC4, 1, 8'h66, 8'h00);
      frame(ID, 8'hA0, 1, 8'h12, 8'h00);
      check("R11 wiper write while busy", wiper_pos, 16'hFF12);
      wait_idle();
      rd_chk(8'hB5, 8'h77, "R8 committed value");
      rd_chk(8'hB4, 8'h5A, "R11 rejected write");

      frame(ID, 8'hC0, 0, 8'h00, 8'h00);
      repeat (2) @(negedge clk);
      check("R8 aborted write no busy", {15'b0, wip}, 16'h0000);
      rd_chk(8'hB0, 8'h80, "R8 aborted write no change");

      frame(ID, 8'hE0, 0, 8'h00, 8'h00);
      hi = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (wip) hi++;
      end
      check("R10 busy length", 16'(hi), 16'(WC));
      rd_chk(8'hB0, 8'h12, "R9 wiper to data register");

      frame(ID, 8'h70, 1, 8'h55, 8'h00);
      frame(ID, 8'hF1, 1, 8'h55, 8'h00);
      check("R12 unknown opcodes", wiper_pos, 16'hFF12);

      coincide(WC, 8'hAB);
      rd_chk(8'hB9, 8'h22, "R11 write on last busy cycle rejected");
      coincide(WC + 1, 8'hCD);
      rd_chk(8'hB9, 8'hCD, "R11 write after busy accepted");
      rd_chk(8'hBC, 8'h5D, "R8 first commit");

      repeat (3) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule